// File: doc/BRIEF.md
# Four-Level Vectored Interrupt Arbiter

This block decides which of seven interrupt sources may interrupt the CPU, and where the CPU must jump. The seven sources are external line 0, timer 0, external line 1, timer 1, the serial channel, the low-voltage detector and the two-wire serial bus. Software writes four byte-wide configuration registers through a simple write port. Two of them hold the per-source enables and the global enable. The other two hold a low and a high priority bit for each of six priority groups. Together, the two priority bits of a group give it one of four levels.

Each cycle the block looks at the pending, enabled requests and picks the one at the highest level. When several requests share that level, a fixed polling order decides. The block then drives a request, the vector address and the winning level towards the CPU. It keeps a four-bit in-service record, one bit per level. The CPU's acknowledge sets the bit for the granted level. A return strobe clears the highest bit that is set. A request is raised only if its level is strictly above every level that is in service.

Top module: `irq_vec_arbiter`

## Requirements
- R1: After a synchronous active-low reset, all enables and priority bits are 0 and no level is in service, so `irq_req` is 0.
- R2: `cfg_sel` selects the register that a write with `cfg_we` high updates: 0 is the main enable register, 1 is the extended enable register, 2 is the low priority bits and 3 is the high priority bits. In the main enable register, bit 7 is the global enable, bits 0..4 enable external 0, timer 0, external 1, timer 1 and serial, and bits 5 and 6 have no effect. In the extended enable register, bit 4 enables low-voltage, bit 5 enables the bus source, and all other bits have no effect. A source with its enable bit at 0 never wins.
- R3: While the global enable is 0, `irq_req` stays 0 whatever the requests and the other enables.
- R4: The level of group x (x = 0..5) is {high bit x, low bit x}, where 3 is the highest and 0 the lowest. Groups 0..5 belong to external 0, timer 0, external 1, timer 1, serial and low-voltage. The bus source uses group 5.
- R5: The vectors are 0x03, 0x0B, 0x13, 0x1B and 0x23 for sources 0..4. They are 0x63 for low-voltage and 0x6B for the bus source.
- R6: Among the active requests, the one at the highest level wins.
- R7: Among active requests at the same level, the lowest source index wins. The index order is external 0, timer 0, external 1, timer 1, serial, low-voltage, then the bus source.
- R8: `irq_req` is 1 only if the winner's level is strictly greater than every in-service level. This includes level 0 when nothing is in service. `irq_ack` while `irq_req` is 1 marks the winner's level as in service. `irq_ack` while `irq_req` is 0 has no effect.
- R9: `irq_ret` clears the highest in-service level. With nothing in service, it has no effect.
- R10: The serial request is the OR of `src_flag[4]` (receive) and `ser_tx_flag` (transmit).
- R11: `irq_level` gives the winner's level while `irq_req` is 1. While `irq_req` is 0, `irq_vector` and `irq_level` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (see R2) |
| cfg_wdata | input | 8 | Register write data |
| src_flag | input | 7 | Request flags; bit 4 is serial receive |
| ser_tx_flag | input | 1 | Serial transmit flag |
| irq_ack | input | 1 | CPU takes the offered interrupt |
| irq_ret | input | 1 | CPU returns from an interrupt |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vector | output | 8 | Vector address of the winner |
| irq_level | output | 2 | Level of the winner |

## Verification
The bench sweeps all 128 request patterns under ten priority configurations, including all-level-0, where only polling order decides. An arbiter that compares levels with a non-strict test, or that scans in the wrong direction, would pick the wrong vector. Every combination of enable bits is swept against a full request set, which catches a shifted enable bit. The bus source is swept against its own priority group, which catches a design that reads a nonexistent group 6. A preemption sequence first fills the in-service record. It then checks four things: that a request at an equal level is held back, that a return pops only the top level, that an acknowledge with no request leaves the record unchanged, and that a level-0 request is offered once the record is empty. A design that pops the lowest level, or that lets equal levels preempt, would offer the wrong vector at some step of this sequence.

// File: rtl/intc_pkg.sv
// Shared constants, register-select codes and vector mapping for the
// four-level interrupt arbiter. Assumes seven sources and six priority groups.
package intc_pkg;
    localparam int NSRC   = 7;
    localparam int NGRP   = 6;
    localparam int NLVL   = 4;
    localparam int LVLW   = $clog2(NLVL);
    localparam int IDXW   = $clog2(NSRC);
    localparam int DATA_W = 8;
    localparam int VEC_W  = 8;

    localparam int SRC_SER = 4;
    localparam int SRC_LVD = 5;
    localparam int SRC_BUS = 6;

    localparam int BIT_GLB  = 7;
    localparam int BIT_LVD  = 4;
    localparam int BIT_BUS  = 5;

    typedef enum logic [1:0] {
        SEL_EN_MAIN = 2'd0,
        SEL_EN_EXT  = 2'd1,
        SEL_PRI_LO  = 2'd2,
        SEL_PRI_HI  = 2'd3
    } cfg_sel_e;

    // Priority group used by a source: the last source shares the last group.
    function automatic int grp_of(int idx);
        return (idx >= NGRP) ? NGRP - 1 : idx;
    endfunction

    // Vector address of a source: 8-byte spacing from 0x03, second bank at 0x63.
    function automatic logic [VEC_W-1:0] vec_of(int idx);
        if (idx < SRC_LVD)
            return VEC_W'(8'h03 + 8 * idx);
        return VEC_W'(8'h63 + 8 * (idx - SRC_LVD));
    endfunction
endpackage

// File: rtl/intc_cfg_regs.sv
// Configuration registers: global enable, per-source enables and the two
// priority bit planes. Write-only from the block's point of view; reserved
// bits are dropped on write.
module intc_cfg_regs
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output logic              glb_en,
    output logic [NSRC-1:0]   src_en,
    output logic [NGRP-1:0]   pri_lo,
    output logic [NGRP-1:0]   pri_hi
);
    logic unused_rsvd;
    assign unused_rsvd = wdata[6];

    // Register update on writes, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_en <= 1'b0;
            src_en <= '0;
            pri_lo <= '0;
            pri_hi <= '0;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                SEL_EN_MAIN: begin
                    glb_en               <= wdata[BIT_GLB];
                    src_en[SRC_SER:0]    <= wdata[SRC_SER:0];
                end
                SEL_EN_EXT: begin
                    src_en[SRC_LVD] <= wdata[BIT_LVD];
                    src_en[SRC_BUS] <= wdata[BIT_BUS];
                end
                SEL_PRI_LO: pri_lo <= wdata[NGRP-1:0];
                default:    pri_hi <= wdata[NGRP-1:0];
            endcase
        end
    end

    AST_EXT_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_EN_EXT) |=> (src_en[SRC_BUS] == $past(wdata[BIT_BUS]) && src_en[SRC_LVD] == $past(wdata[BIT_LVD]))); // R2
    AST_NO_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!we) |=> ($stable(src_en) && $stable(pri_lo) && $stable(pri_hi) && $stable(glb_en))); // R2
endmodule

// File: rtl/intc_arbiter.sv
// Combinational winner selection: masks requests by the enables, builds each
// source's 2-bit level from its group's bit pair, then picks the highest level,
// with the lowest index winning ties.
module intc_arbiter
    import intc_pkg::*;
(
    input  logic            glb_en,
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] src_en,
    input  logic [NGRP-1:0] pri_lo,
    input  logic [NGRP-1:0] pri_hi,
    output logic            win_valid,
    output logic [IDXW-1:0] win_idx,
    output logic [LVLW-1:0] win_lvl
);
    logic [LVLW-1:0] lvl [NSRC];
    logic [NSRC-1:0] act;

    assign act = req & src_en & {NSRC{glb_en}};

    for (genvar s = 0; s < NSRC; s++) begin : g_lvl
        localparam int G = grp_of(s);
        assign lvl[s] = {pri_hi[G], pri_lo[G]};
    end

    // Scan from the last source down; ">=" lets lower indices take ties.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_lvl   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (act[i] && (!win_valid || lvl[i] >= win_lvl)) begin
                win_valid = 1'b1;
                win_idx   = IDXW'(i);
                win_lvl   = lvl[i];
            end
        end
    end
endmodule

// File: rtl/intc_inservice.sv
// In-service record, one bit per level. Grants a winner only above every set
// bit; acknowledge sets the granted level, return clears the highest set bit.
// Assumes return is applied before acknowledge when both arrive together.
module intc_inservice
    import intc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            win_valid,
    input  logic [LVLW-1:0] win_lvl,
    input  logic            ack,
    input  logic            ret,
    output logic            grant
);
    logic [NLVL-1:0] isv_q;
    logic [NLVL-1:0] isv_d;
    logic [NLVL-1:0] top_oh;
    logic            blocked;

    // Blocked if any in-service level is at or above the winner's level.
    always_comb begin
        blocked = 1'b0;
        for (int l = 0; l < NLVL; l++)
            if (isv_q[l] && l >= int'(win_lvl))
                blocked = 1'b1;
    end

    assign grant = win_valid && !blocked;

    // One-hot of the highest in-service level.
    always_comb begin
        top_oh = '0;
        for (int l = 0; l < NLVL; l++)
            if (isv_q[l])
                top_oh = NLVL'(1) << l;
    end

    // Next record: pop on return, then push on acknowledge.
    always_comb begin
        isv_d = isv_q;
        if (ret)
            isv_d = isv_d & ~top_oh;
        if (ack && grant)
            isv_d = isv_d | (NLVL'(1) << win_lvl);
    end

    // Record register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            isv_q <= '0;
        else
            isv_q <= isv_d;
    end

    AST_ACK_PUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && grant && !ret) |=> ($countones(isv_q) == $past($countones(isv_q)) + 1)); // R8
    AST_IDLE_ACK_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !grant && !ret) |=> $stable(isv_q)); // R8
    AST_RET_POPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !ack && isv_q != '0) |=> ($countones(isv_q) == $past($countones(isv_q)) - 1)); // R9
    AST_RET_KEEPS_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !ack) |=> ((isv_q & ~$past(isv_q)) == '0)); // R9
endmodule

// File: rtl/irq_vec_arbiter.sv
// Top of the four-level vectored interrupt arbiter. Merges the serial
// receive/transmit flags, selects a winner and gates it with the in-service
// record. Outputs are combinational from registered state and the inputs.
module irq_vec_arbiter
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [NSRC-1:0]   src_flag,
    input  logic              ser_tx_flag,
    input  logic              irq_ack,
    input  logic              irq_ret,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vector,
    output logic [LVLW-1:0]   irq_level
);
    logic            glb_en;
    logic [NSRC-1:0] src_en;
    logic [NGRP-1:0] pri_lo;
    logic [NGRP-1:0] pri_hi;
    logic [NSRC-1:0] req;
    logic            win_valid;
    logic [IDXW-1:0] win_idx;
    logic [LVLW-1:0] win_lvl;
    logic            grant;

    // Serial request is receive OR transmit.
    always_comb begin
        req          = src_flag;
        req[SRC_SER] = src_flag[SRC_SER] | ser_tx_flag;
    end

    intc_cfg_regs u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .sel    (cfg_sel),
        .wdata  (cfg_wdata),
        .glb_en (glb_en),
        .src_en (src_en),
        .pri_lo (pri_lo),
        .pri_hi (pri_hi)
    );

    intc_arbiter u_arb (
        .glb_en    (glb_en),
        .req       (req),
        .src_en    (src_en),
        .pri_lo    (pri_lo),
        .pri_hi    (pri_hi),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_lvl   (win_lvl)
    );

    intc_inservice u_isv (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_valid (win_valid),
        .win_lvl   (win_lvl),
        .ack       (irq_ack),
        .ret       (irq_ret),
        .grant     (grant)
    );

    // Output drive: vector and level only while a request is offered.
    always_comb begin
        irq_req    = grant;
        irq_vector = grant ? vec_of(int'(win_idx)) : '0;
        irq_level  = grant ? win_lvl : '0;
    end

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en) |-> !irq_req); // R3
    AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vector[2:0] == 3'b011 && (irq_vector < 8'h28 || irq_vector == 8'h63 || irq_vector == 8'h6B))); // R5
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req) |-> (irq_vector == '0 && irq_level == '0)); // R11
    AST_DISABLED_NEVER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> src_en[win_idx]); // R2
endmodule

// File: tb/irq_vec_arbiter_tb.sv
// Self-checking bench: sweeps request patterns, enable masks and priority
// configurations against an arithmetic model, then walks a preemption sequence.
module irq_vec_arbiter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic [6:0] src_flag = 7'd0;
    logic       ser_tx_flag = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq_ret = 1'b0;
    logic       irq_req;
    logic [7:0] irq_vector;
    logic [1:0] irq_level;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] m_en0 = 0, m_en1 = 0, m_p0 = 0, m_p1 = 0;
    logic [3:0] m_isv = 0;

    always #2 clk = ~clk;

    irq_vec_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .src_flag(src_flag), .ser_tx_flag(ser_tx_flag),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req),
        .irq_vector(irq_vector), .irq_level(irq_level)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(int sel, logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            0: m_en0 = d;
            1: m_en1 = d;
            2: m_p0 = d;
            default: m_p1 = d;
        endcase
    endtask

    function automatic int exp_vec(int idx);
        return (idx < 5) ? 3 + 8 * idx : 99 + 8 * (idx - 5);
    endfunction

    // Model of selection and in-service gating.
    task automatic predict(input logic [6:0] raw, output bit v, output int idx, output int lv);
        logic [6:0] en;
        en = {m_en1[5], m_en1[4], m_en0[4:0]} & {7{m_en0[7]}};
        v = 0; idx = 0; lv = 0;
        for (int i = 0; i < 7; i++) begin
            int g;
            int l;
            g = (i == 6) ? 5 : i;
            l = 2 * m_p1[g] + m_p0[g];
            if (raw[i] && en[i] && (!v || l > lv)) begin
                v = 1; idx = i; lv = l;
            end
        end
        for (int l = 0; l < 4; l++)
            if (v && m_isv[l] && l >= lv) v = 0;
    endtask

    task automatic drive(logic [6:0] raw, bit tx_mode);
        @(negedge clk);
        src_flag = raw;
        ser_tx_flag = 1'b0;
        if (tx_mode) begin
            src_flag[4] = 1'b0;
            ser_tx_flag = raw[4];
        end
        #1;
    endtask

    task automatic check_out(string tag, logic [6:0] raw);
        bit v; int idx; int lv;
        predict(raw, v, idx, lv);
        check({tag, " req"}, int'(irq_req), int'(v));
        check({tag, " vec"}, int'(irq_vector), v ? exp_vec(idx) : 0);
        check({tag, " lvl"}, int'(irq_level), v ? lv : 0);
    endtask

    task automatic pulse_ack();
        bit v; int idx; int lv;
        predict(src_flag | {2'b0, ser_tx_flag, 4'b0}, v, idx, lv);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        if (v) m_isv[lv] = 1'b1;
    endtask

    task automatic pulse_ret();
        @(negedge clk); irq_ret = 1'b1;
        @(negedge clk); irq_ret = 1'b0;
        for (int l = 3; l >= 0; l--)
            if (m_isv[l]) begin m_isv[l] = 1'b0; break; end
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, all requests present but nothing enabled
        drive(7'h7F, 0);
        check("R1 reset req", int'(irq_req), 0);
        check("R1 reset vec", int'(irq_vector), 0);

        // R3: global enable off, every source enabled
        wr(0, 8'h1F); wr(1, 8'h30);
        for (int p = 0; p < 128; p += 9) begin
            drive(7'(p), 0);
            check("R3 masked", int'(irq_req), 0);
        end

        // R2: enable-mask sweep with all requests, all level 0; reserved bits set
        for (int m = 0; m < 128; m++) begin
            wr(0, {1'b1, 2'b11, 5'(m)});
            wr(1, {2'b11, m[6], m[5], 4'hF});
            drive(7'h7F, m[0]);
            check_out("R2 enable sweep", 7'h7F);
        end

        // R4 R5 R6 R7 R10 R11: pattern sweep over priority configurations
        wr(0, 8'h9F); wr(1, 8'h30);
        for (int k = 0; k < 10; k++) begin
            logic [7:0] a;
            logic [7:0] b;
            a = (k == 0) ? 8'h00 : (k == 9) ? 8'h3F : 8'(k * 37 + 5);
            b = (k == 0) ? 8'h00 : (k == 9) ? 8'h3F : 8'(k * 91 + 3);
            wr(2, a & 8'h3F); wr(3, b & 8'h3F);
            for (int p = 0; p < 128; p++) begin
                drive(7'(p), k[0]);
                check_out("R6 R7 R10 sweep", 7'(p));
            end
        end

        // R4: bus source follows group 5 against low-voltage and serial
        wr(2, 8'h00); wr(3, 8'h20);
        drive(7'b1010000, 0);
        check("R4 bus group5 vec", int'(irq_vector), 8'h6B);
        check("R4 bus group5 lvl", int'(irq_level), 2);
        drive(7'b1110000, 1);
        check("R7 lvd before bus", int'(irq_vector), 8'h63);

        // R10: receive and transmit together
        wr(3, 8'h00);
        @(negedge clk); src_flag = 7'h10; ser_tx_flag = 1'b1; #1;
        check("R10 rx|tx vec", int'(irq_vector), 8'h23);

        // R8 R9: preemption walk; ext0=lvl1, tmr0=lvl2, ext1=lvl3, tmr1=lvl0
        wr(2, 8'b000101); wr(3, 8'b000110);
        drive(7'b0000001, 0);
        check_out("R8 lvl1 offered", 7'b0000001);
        pulse_ack();
        drive(7'b0000001, 0);
        check("R8 equal level held", int'(irq_req), 0);
        drive(7'b0000011, 0);
        check_out("R8 higher preempts", 7'b0000011);
        pulse_ack();
        drive(7'b0000111, 0);
        check_out("R8 lvl3 offered", 7'b0000111);
        pulse_ack();
        drive(7'b0001111, 0);
        check("R8 all busy", int'(irq_req), 0);
        pulse_ack();
        drive(7'b0001111, 0);
        check("R8 idle ack ignored", int'(irq_req), 0);
        pulse_ret();
        drive(7'b0001111, 0);
        check_out("R9 pop top", 7'b0001111);
        check("R9 pop top vec", int'(irq_vector), 8'h13);
        drive(7'b0001011, 0);
        check("R9 lvl2 still busy", int'(irq_req), 0);
        pulse_ret();
        drive(7'b0001011, 0);
        check("R9 lvl2 freed vec", int'(irq_vector), 8'h0B);
        pulse_ret();
        pulse_ret();
        drive(7'b0001000, 0);
        check("R8 lvl0 allowed when empty", int'(irq_req), 1);
        check("R8 lvl0 vec", int'(irq_vector), 8'h1B);
        pulse_ret();
        drive(7'b0001000, 0);
        check("R9 ret on empty", int'(irq_req), 1);

        // R1: reset again clears configuration and record
        pulse_ack();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_en0 = 0; m_en1 = 0; m_p0 = 0; m_p1 = 0; m_isv = 0;
        drive(7'h7F, 0);
        check("R1 re-reset req", int'(irq_req), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule